// File: doc/BRIEF.md
# Switch-control sequence generator

This block produces three control levels (reset, select and hold) for a switched-integrator front end. A rising edge on the trigger input starts a sequence of `ROWS` row phases. The rows rise one by one, each a programmable step time after the one before, and the first row rises one step after the trigger.

Six event columns can each be tied to any one row. When the row tied to a column rises, that column either opens or closes one of the three controls. Each control therefore has one open event and one close event, and both can be placed anywhere in the sequence. The step time and the column routing are written through a small configuration port, and only while the sequencer is idle.

Top module: `switch_seq_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `ctl_reset`, `ctl_select` and `ctl_hold` are 1 (open), `busy` is 0, `rows` is all zeros, `route_err` is 0 and `ovr_cnt` is 0.
- R2: Let P be the step value. A rising `trig` (1 sampled at a clock edge, 0 at the edge before) seen while idle sets `busy` and clears `rows` at that edge E0. Row k (0-based) rises at edge E0+(k+1)*(P+1) and stays high until the next sequence starts. `busy` falls at the edge where row `ROWS-1` rises.
- R3: `cfg_we` with `cfg_addr` 0..5 writes the low bits of `cfg_wdata` as the row index of column 0..5. `cfg_addr` 6 writes the step value P. Any write made while `busy` is 1 is ignored.
- R4: Column 0 rising sets `ctl_reset` to 0 (closed), and column 1 sets it to 1 (open). Each takes effect at the edge where its row rises.
- R5: Column 2 rising sets `ctl_select` to 0, and column 3 sets it to 1.
- R6: Column 4 rising sets `ctl_hold` to 1 (open), and column 5 sets it to 0 (closed).
- R7: A column whose row index is `ROWS` or more produces no event. After reset every column holds the all-ones index.
- R8: If the open and close columns of one control rise at the same row, the control opens (goes to 1) and `route_err` becomes 1. It stays 1 until reset.
- R9: A rising `trig` while `busy` is 1 does not restart or alter the sequence. It increments `ovr_cnt`, which saturates at all ones.
- R10: Only rising edges start a sequence. A `trig` held high past the end of a sequence does not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Sequence trigger, synchronous to `clk` |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | 0..5 column route, 6 step value |
| cfg_wdata | input | PRE_W | Configuration write data |
| busy | output | 1 | Sequence in progress |
| rows | output | ROWS | Row levels of the current or last sequence |
| ctl_reset | output | 1 | Reset control, 1 = open |
| ctl_select | output | 1 | Select control, 1 = open |
| ctl_hold | output | 1 | Hold control, 1 = open |
| route_err | output | 1 | Sticky open/close collision flag |
| ovr_cnt | output | OVR_W | Saturating count of triggers that arrived while busy |

## Verification
The assertions assume that `trig` and the configuration inputs are synchronous to `clk`. They also assume that a control changes only at a step boundary, so they treat any change of a control between steps as an error. The bench drives every input on the falling edge, keeps each trigger pulse high for two cycles and low for at least one, and issues configuration writes both while idle and in the middle of a sequence. A behavioural model counts the cycles elapsed since the start of the sequence and divides by the step length, which is a different method from the design's own counters. The bench compares all outputs against this model on every cycle.

// File: rtl/switch_seq_gen.sv
module switch_seq_gen #(
  parameter int ROWS  = 10,
  parameter int PRE_W = 16,
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [PRE_W-1:0] cfg_wdata,
  output logic             busy,
  output logic [ROWS-1:0]  rows,
  output logic             ctl_reset,
  output logic             ctl_select,
  output logic             ctl_hold,
  output logic             route_err,
  output logic [OVR_W-1:0] ovr_cnt
);
  localparam int RW   = $clog2(ROWS + 1);
  localparam int NCOL = 6;

  logic [RW-1:0]    route [NCOL];
  logic [PRE_W-1:0] pre, cnt;
  logic [RW-1:0]    ph;
  logic             trig_q;
  logic [2:0]       lvl;
  logic [NCOL-1:0]  hit;

  wire trig_rise = trig & ~trig_q;
  wire step      = busy && (cnt == pre);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign hit[c] = step && (route[c] == ph);
  end

  wire [2:0] open_ev  = {hit[4], hit[3], hit[1]};
  wire [2:0] close_ev = {hit[5], hit[2], hit[0]};

  assign ctl_reset  = lvl[0];
  assign ctl_select = lvl[1];
  assign ctl_hold   = lvl[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCOL; c++) route[c] <= '1;
      pre <= '0;
    end else if (cfg_we && !busy) begin
      for (int c = 0; c < NCOL; c++)
        if (cfg_addr == 3'(c)) route[c] <= cfg_wdata[RW-1:0];
      if (cfg_addr == 3'd6) pre <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      ph      <= '0;
      rows    <= '0;
      ovr_cnt <= '0;
    end else begin
      trig_q <= trig;
      if (busy) begin
        if (step) begin
          cnt  <= '0;
          ph   <= ph + 1'b1;
          rows <= rows | (ROWS'(1) << ph);
          if (ph == RW'(ROWS - 1)) busy <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        if (trig_rise && ovr_cnt != '1) ovr_cnt <= ovr_cnt + 1'b1;
      end else if (trig_rise) begin
        busy <= 1'b1;
        cnt  <= '0;
        ph   <= '0;
        rows <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl       <= 3'b111;
      route_err <= 1'b0;
    end else begin
      for (int i = 0; i < 3; i++)
        lvl[i] <= open_ev[i] ? 1'b1 : (close_ev[i] ? 1'b0 : lvl[i]);
      if (|(open_ev & close_ev)) route_err <= 1'b1;
    end
  end

  a_r2_ends_on_last_row: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rows[ROWS-1]);

  a_r3_step_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pre));

  a_r4_levels_move_on_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable({ctl_hold, ctl_select, ctl_reset}));

  a_r8_open_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[0] && hit[1]) |=> (ctl_reset && route_err));

  a_r9_overrun_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig_rise && ovr_cnt != '1) |=> (ovr_cnt == $past(ovr_cnt) + 1'b1));

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> busy);
endmodule

// File: tb/test_switch_seq_gen.sv
module test_switch_seq_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 10;
  localparam int PRE_W = 16;
  localparam int OVR_W = 3;
  localparam int RW    = $clog2(ROWS + 1);
  localparam int OVMAX = (1 << OVR_W) - 1;

  logic clk = 0, rst_n = 0, trig = 0, cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [PRE_W-1:0] cfg_wdata = 0;
  logic busy, ctl_reset, ctl_select, ctl_hold, route_err;
  logic [ROWS-1:0] rows;
  logic [OVR_W-1:0] ovr_cnt;

  switch_seq_gen #(.ROWS(ROWS), .PRE_W(PRE_W), .OVR_W(OVR_W)) i_switch_seq_gen (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .rows(rows), .ctl_reset(ctl_reset),
    .ctl_select(ctl_select), .ctl_hold(ctl_hold), .route_err(route_err), .ovr_cnt(ovr_cnt));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R1";

  bit mbusy, mtq, mres, msel, mhold, merr;
  bit [ROWS-1:0] mrows;
  int mel, mpre, movr;
  int mroute [6];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbusy = 0; mtq = 0; mres = 1; msel = 1; mhold = 1; merr = 0;
      mrows = '0; mel = 0; mpre = 0; movr = 0;
      foreach (mroute[c]) mroute[c] = (1 << RW) - 1;
    end else begin
      bit ob, rise;
      ob = mbusy;
      rise = trig && !mtq;
      mtq = trig;
      if (cfg_we && !ob) begin
        if (cfg_addr < 6) mroute[cfg_addr] = int'(cfg_wdata) & ((1 << RW) - 1);
        else if (cfg_addr == 6) mpre = int'(cfg_wdata);
      end
      if (ob) begin
        mel++;
        if (mel % (mpre + 1) == 0) begin
          int k;
          k = mel / (mpre + 1) - 1;
          mrows[k] = 1;
          if (mroute[1] == k) mres = 1; else if (mroute[0] == k) mres = 0;
          if (mroute[3] == k) msel = 1; else if (mroute[2] == k) msel = 0;
          if (mroute[4] == k) mhold = 1; else if (mroute[5] == k) mhold = 0;
          if ((mroute[0] == k && mroute[1] == k) || (mroute[2] == k && mroute[3] == k) ||
              (mroute[4] == k && mroute[5] == k)) merr = 1;
          if (k == ROWS - 1) mbusy = 0;
        end
      end
      if (rise) begin
        if (ob) begin
          if (movr < OVMAX) movr++;
        end else begin
          mbusy = 1; mel = 0; mrows = '0;
        end
      end
    end
  end

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(tag, "busy", busy, mbusy);
    chk(tag, "rows", rows, mrows);
    chk(tag, "ctl_reset", ctl_reset, mres);
    chk(tag, "ctl_select", ctl_select, msel);
    chk(tag, "ctl_hold", ctl_hold, mhold);
    chk(tag, "route_err", route_err, merr);
    chk(tag, "ovr_cnt", ovr_cnt, movr);
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = PRE_W'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse();
    @(negedge clk); trig = 1;
    @(negedge clk);
    @(negedge clk); trig = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic unroute();
    for (int c = 0; c < 6; c++) wr(c, 15);
  endtask

  task automatic run_len(output int n);
    n = 0;
    @(negedge clk); trig = 1;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); trig = 0; end
    trig = 0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1", "reset ctl_reset", ctl_reset, 1);
    chk("R1", "reset ctl_select", ctl_select, 1);
    chk("R1", "reset ctl_hold", ctl_hold, 1);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset rows", rows, 0);
    chk("R1", "reset err", route_err, 0);
    chk("R1", "reset ovr", ovr_cnt, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    tag = "R7"; wr(6, 2); pulse(); wait_idle();
    chk("R7", "unrouted ctl", {ctl_hold, ctl_select, ctl_reset}, 7);
    chk("R2", "all rows risen", rows, (1 << ROWS) - 1);

    tag = "R4"; wr(0, 1); wr(1, 5); pulse();
    while (!rows[2]) @(negedge clk);
    chk("R4", "reset closed mid-sequence", ctl_reset, 0);
    wait_idle();
    chk("R4", "reset reopened", ctl_reset, 1);

    tag = "R5"; unroute(); wr(3, 1); wr(2, 7); pulse(); wait_idle();
    chk("R5", "select closed at end", ctl_select, 0);

    tag = "R6"; unroute(); wr(4, 1); wr(5, 3); pulse(); wait_idle();
    chk("R6", "hold closed at end", ctl_hold, 0);
    wr(5, 2); wr(4, 8); pulse(); wait_idle();
    chk("R6", "hold reopened", ctl_hold, 1);

    tag = "R8"; unroute(); wr(0, 4); wr(1, 4); pulse(); wait_idle();
    chk("R8", "collision opens", ctl_reset, 1);
    chk("R8", "collision flag", route_err, 1);

    tag = "R3"; unroute(); wr(6, 5); wr(2, 0);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    wr(6, 0); wr(3, 9); wr(2, 15);
    wait_idle();
    run_len(n);
    chk("R3", "busy writes ignored, step kept", n, ROWS * 6);
    chk("R3", "busy route write ignored", ctl_select, 0);

    tag = "R2"; wr(6, 0); run_len(n);
    chk("R2", "one-cycle step length", n, ROWS);
    wait_idle();
    chk("R2", "rows after short run", rows, (1 << ROWS) - 1);

    tag = "R9"; wr(6, 20); pulse();
    for (int i = 0; i < 9; i++) pulse();
    chk("R9", "still busy after overruns", busy, 1);
    chk("R9", "overrun saturated", ovr_cnt, OVMAX);
    wait_idle();

    tag = "R10"; wr(6, 0);
    @(negedge clk); trig = 1;
    repeat (40) @(negedge clk);
    chk("R10", "held trigger no restart", busy, 0);
    trig = 0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule